// File: doc/BRIEF.md
# Character Display Command Processor

This block is the command side of a character-display controller. A host talks to it over a byte-wide parallel register port with a strobe, a register-select line (instruction or data) and a read/write line. Instruction bytes are decoded into mode changes, address loads, cursor or display shifts, and the long clear and home operations. Data bytes go to, or come from, the display-data RAM or the character-generator RAM, whichever an address instruction last selected.

A single address counter serves both RAMs. Every data access steps it up or down according to the entry mode, and the step wraps inside the address space of the selected RAM. When the entry mode asks for it, each data access also moves a display shift offset. Every accepted command starts a busy period, counted in clock cycles derived from a clock-frequency parameter. While that period runs, further commands and data accesses have no effect. The host can read the busy flag together with the address counter at any time.

Top module: `chardisp_cmd`

## Requirements
- R1: After reset: busy 0, address counter 0 with display-data RAM selected, increment on and auto-shift off, display, cursor and blink off, 8-bit bus on, one line, short font, shift offset 0, every display-data byte 0x20, every character-generator byte 0x00.
- R2: An instruction byte is decoded by its highest set bit: bit7 display-data address, bit6 character-generator address, bit5 function set, bit4 shift, bit3 display control, bit2 entry mode, bit1 home, bit0 clear. The byte 0x00 has no effect and starts no busy period.
- R3: Clear writes 0x20 to every display-data byte, zeroes the address counter and the shift offset, and selects display-data RAM.
- R4: Home zeroes the address counter and the shift offset and selects display-data RAM. It leaves both RAMs unchanged.
- R5: Entry mode loads increment from bit1 and auto-shift from bit0. Display control loads display-on from bit2, cursor-on from bit1 and blink from bit0. Function set loads 8-bit bus from bit4, two lines from bit3 and tall font from bit2.
- R6: The shift instruction with bit3=1 moves the shift offset: bit2=1 (right) subtracts 1 and bit2=0 adds 1, modulo 128. With bit3=0 it steps the address counter: bit2=1 adds 1 and bit2=0 subtracts 1, wrapping in the selected RAM's space. RAM contents do not change.
- R7: The character-generator address instruction loads bits 5:0 into the counter. The display-data address instruction loads bits 6:0. Each selects its RAM for the data transfers that follow.
- R8: A data write stores the byte at the counter in the selected RAM. The counter then steps by +1 (increment on) or -1, modulo 128 for display-data RAM and modulo 64 for character-generator RAM. With auto-shift on, the offset also steps +1 (increment) or -1, modulo 128.
- R9: During a data read, the read port shows the selected RAM's byte at the counter. The access then steps the counter and the offset exactly as a write does.
- R10: A status read shows the busy flag in bit 7 and the counter in bits 6:0. It changes nothing, starts no busy period and is honoured while busy.
- R11: An accepted command raises busy from the next cycle, for round(CLK_HZ·t) cycles: t = 1.52 ms for clear and home, and 37 µs for every other instruction and for data accesses. At the default 270 kHz this is 410 and 10 cycles.
- R12: Instruction writes, data writes and data reads presented while busy is 1 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_en | input | 1 | Access strobe, one access per cycle it is high |
| bus_rs | input | 1 | 0 selects instruction/status, 1 selects data |
| bus_rw | input | 1 | 1 reads, 0 writes |
| bus_wdata | input | 8 | Write byte |
| bus_rdata | output | 8 | Status word or RAM byte, per bus_rs |
| busy | output | 1 | Busy flag |
| disp_on | output | 1 | Characters shown |
| cursor_on | output | 1 | Cursor shown |
| blink_on | output | 1 | Character at cursor blinks |
| entry_inc | output | 1 | Counter direction, 1 increments |
| entry_shift | output | 1 | Data accesses also shift the display |
| bus_8bit | output | 1 | 8-bit host bus width selected |
| two_lines | output | 1 | Two display lines selected |
| tall_font | output | 1 | 5x10 font selected |
| disp_offset | output | 7 | Display shift offset |

## Verification
The embedded properties watch, on every cycle, that the busy counter only counts down between loads, that nothing in the mode or offset state moves while a request meets a busy controller, that status reads never start a busy period, that the counter stays inside 64 entries while character-generator RAM is selected, and that clear and home leave the offset at zero with busy raised. Wrap-around in both address spaces and in both directions, the highest-bit decode of bytes with several bits set, the exact length of long and short busy periods, and the fact that ignored writes leave RAM unchanged can only be shown by the bench's scenarios. These scenarios are checked against the reference model and read back through the data port.

// File: rtl/chardisp_pkg.sv
package chardisp_pkg;

  localparam int DD_AW = 7;
  localparam int CG_AW = 6;
  localparam int DW    = 8;

  typedef enum logic [3:0] {
    OP_NONE, OP_CLEAR, OP_HOME, OP_ENTRY, OP_DISPCTL,
    OP_SHIFT, OP_FUNC, OP_CGADDR, OP_DDADDR
  } op_e;

  typedef enum logic { TGT_DD, TGT_CG } tgt_e;

  // highest set bit picks the command
  function automatic op_e decode_op(input logic [7:0] b);
    op_e r;
    if (b[7])      r = OP_DDADDR;
    else if (b[6]) r = OP_CGADDR;
    else if (b[5]) r = OP_FUNC;
    else if (b[4]) r = OP_SHIFT;
    else if (b[3]) r = OP_DISPCTL;
    else if (b[2]) r = OP_ENTRY;
    else if (b[1]) r = OP_HOME;
    else if (b[0]) r = OP_CLEAR;
    else           r = OP_NONE;
    return r;
  endfunction

  // one step of the shared counter inside the selected space
  function automatic logic [DD_AW-1:0] step_addr(input logic [DD_AW-1:0] a,
                                                 input logic up,
                                                 input tgt_e t);
    logic [CG_AW-1:0] lo;
    logic [DD_AW-1:0] r;
    if (t == TGT_CG) begin
      lo = a[CG_AW-1:0];
      lo = up ? lo + 1'b1 : lo - 1'b1;
      r  = {{(DD_AW-CG_AW){1'b0}}, lo};
    end else begin
      r = up ? a + 1'b1 : a - 1'b1;
    end
    return r;
  endfunction

  // rounded cycle count for a duration given in nanoseconds
  function automatic int cycles_for(input longint hz, input longint ns);
    return int'((hz * ns + 64'd500_000_000) / 64'd1_000_000_000);
  endfunction

endpackage

// File: rtl/cd_decode.sv
module cd_decode
  import chardisp_pkg::*;
(
  input  logic [7:0] inst,
  output op_e        op,
  output logic       long_op
);
  always_comb begin
    op      = decode_op(inst);
    long_op = (op == OP_CLEAR) || (op == OP_HOME);
  end
endmodule

// File: rtl/cd_busy_timer.sv
module cd_busy_timer #(
  parameter int LONG_CYC  = 410,
  parameter int SHORT_CYC = 10,
  localparam int CNT_W    = $clog2(LONG_CYC + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic long_sel,
  output logic busy
);
  localparam logic [CNT_W-1:0] LONG_V  = CNT_W'(LONG_CYC);
  localparam logic [CNT_W-1:0] SHORT_V = CNT_W'(SHORT_CYC);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (load)         cnt <= long_sel ? LONG_V : SHORT_V;
    else if (cnt != '0)    cnt <= cnt - 1'b1;
  end

  assign busy = (cnt != '0);

  // R11
  busy_countdown_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !load) |=> (cnt == $past(cnt) - 1'b1));

  // R11
  load_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt == ($past(long_sel) ? LONG_V : SHORT_V)));
endmodule

// File: rtl/cd_addr_ctr.sv
module cd_addr_ctr
  import chardisp_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  op_e              op,
  input  logic [6:0]       inst_lo,
  input  logic             acc_inst,
  input  logic             acc_data,
  input  logic             dir_up,
  output logic [DD_AW-1:0] ac,
  output tgt_e             tgt
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ac  <= '0;
      tgt <= TGT_DD;
    end else if (acc_inst) begin
      case (op)
        OP_CLEAR, OP_HOME: begin
          ac  <= '0;
          tgt <= TGT_DD;
        end
        OP_SHIFT: if (!inst_lo[3]) ac <= step_addr(ac, inst_lo[2], tgt);
        OP_CGADDR: begin
          ac  <= {{(DD_AW-CG_AW){1'b0}}, inst_lo[CG_AW-1:0]};
          tgt <= TGT_CG;
        end
        OP_DDADDR: begin
          ac  <= inst_lo[DD_AW-1:0];
          tgt <= TGT_DD;
        end
        default: ;
      endcase
    end else if (acc_data) begin
      ac <= step_addr(ac, dir_up, tgt);
    end
  end

  // R8
  cg_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tgt == TGT_CG) |-> (ac[DD_AW-1:CG_AW] == '0));

  // R7
  dd_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_inst && op == OP_DDADDR) |=> (ac == $past(inst_lo) && tgt == TGT_DD));
endmodule

// File: rtl/cd_char_store.sv
module cd_char_store
  import chardisp_pkg::*;
#(
  parameter logic [DW-1:0] BLANK = 8'h20,
  localparam int DD_DEPTH = 1 << DD_AW,
  localparam int CG_DEPTH = 1 << CG_AW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             we,
  input  logic             sel_cg,
  input  logic [DD_AW-1:0] addr,
  input  logic [DW-1:0]    wdata,
  output logic [DW-1:0]    rdata
);
  logic [DW-1:0] dd_mem [DD_DEPTH];
  logic [DW-1:0] cg_mem [CG_DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DD_DEPTH; i++) dd_mem[i] <= BLANK;
    end else if (clear) begin
      for (int i = 0; i < DD_DEPTH; i++) dd_mem[i] <= BLANK;
    end else if (we && !sel_cg) begin
      dd_mem[addr] <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < CG_DEPTH; i++) cg_mem[i] <= '0;
    end else if (we && sel_cg) begin
      cg_mem[addr[CG_AW-1:0]] <= wdata;
    end
  end

  assign rdata = sel_cg ? cg_mem[addr[CG_AW-1:0]] : dd_mem[addr];

  // R3
  clear_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (dd_mem[0] == BLANK && dd_mem[DD_DEPTH-1] == BLANK));

  // R8
  dd_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we && !sel_cg && !clear) |=> (dd_mem[$past(addr)] == $past(wdata)));
endmodule

// File: rtl/chardisp_cmd.sv
module chardisp_cmd
  import chardisp_pkg::*;
#(
  parameter int CLK_HZ   = 270_000,
  parameter int LONG_NS  = 1_520_000,
  parameter int SHORT_NS = 37_000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_en,
  input  logic       bus_rs,
  input  logic       bus_rw,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic       busy,
  output logic       disp_on,
  output logic       cursor_on,
  output logic       blink_on,
  output logic       entry_inc,
  output logic       entry_shift,
  output logic       bus_8bit,
  output logic       two_lines,
  output logic       tall_font,
  output logic [6:0] disp_offset
);
  localparam int LONG_CYC  = cycles_for(64'(CLK_HZ), 64'(LONG_NS));
  localparam int SHORT_CYC = cycles_for(64'(CLK_HZ), 64'(SHORT_NS));

  // named internal events
  op_e              op;
  logic             long_op;
  logic             inst_wr, data_acc, acc_inst, acc_data;
  logic [DD_AW-1:0] ac;
  tgt_e             tgt;
  logic [DW-1:0]    ram_rdata;

  assign inst_wr  = bus_en && !bus_rs && !bus_rw;
  assign data_acc = bus_en && bus_rs;
  assign acc_inst = inst_wr && !busy && (op != OP_NONE);
  assign acc_data = data_acc && !busy;

  cd_decode u_dec (
    .inst    (bus_wdata),
    .op      (op),
    .long_op (long_op)
  );

  cd_busy_timer #(
    .LONG_CYC  (LONG_CYC),
    .SHORT_CYC (SHORT_CYC)
  ) u_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (acc_inst || acc_data),
    .long_sel (acc_inst && long_op),
    .busy     (busy)
  );

  cd_addr_ctr u_ac (
    .clk      (clk),
    .rst_n    (rst_n),
    .op       (op),
    .inst_lo  (bus_wdata[6:0]),
    .acc_inst (acc_inst),
    .acc_data (acc_data),
    .dir_up   (entry_inc),
    .ac       (ac),
    .tgt      (tgt)
  );

  cd_char_store u_ram (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear  (acc_inst && op == OP_CLEAR),
    .we     (acc_data && !bus_rw),
    .sel_cg (tgt == TGT_CG),
    .addr   (ac),
    .wdata  (bus_wdata),
    .rdata  (ram_rdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      entry_inc   <= 1'b1;
      entry_shift <= 1'b0;
      disp_on     <= 1'b0;
      cursor_on   <= 1'b0;
      blink_on    <= 1'b0;
      bus_8bit    <= 1'b1;
      two_lines   <= 1'b0;
      tall_font   <= 1'b0;
      disp_offset <= '0;
    end else if (acc_inst) begin
      case (op)
        OP_CLEAR, OP_HOME: disp_offset <= '0;
        OP_ENTRY: begin
          entry_inc   <= bus_wdata[1];
          entry_shift <= bus_wdata[0];
        end
        OP_DISPCTL: begin
          disp_on   <= bus_wdata[2];
          cursor_on <= bus_wdata[1];
          blink_on  <= bus_wdata[0];
        end
        OP_FUNC: begin
          bus_8bit  <= bus_wdata[4];
          two_lines <= bus_wdata[3];
          tall_font <= bus_wdata[2];
        end
        OP_SHIFT: if (bus_wdata[3])
          disp_offset <= bus_wdata[2] ? disp_offset - 1'b1 : disp_offset + 1'b1;
        default: ;
      endcase
    end else if (acc_data && entry_shift) begin
      disp_offset <= entry_inc ? disp_offset + 1'b1 : disp_offset - 1'b1;
    end
  end

  assign bus_rdata = bus_rs ? ram_rdata : {busy, ac};

  // R12
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && bus_en) |=> $stable({entry_inc, entry_shift, disp_on, cursor_on, blink_on,
                                  bus_8bit, two_lines, tall_font, disp_offset}));

  // R4
  home_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_inst && long_op) |=> (disp_offset == '0 && busy));

  // R10
  status_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && !bus_rs && bus_rw && !busy) |=> !busy);
endmodule

// File: tb/sim_chardisp_cmd.sv
`timescale 1ns/100ps
module sim_chardisp_cmd;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic       rst_n, bus_en, bus_rs, bus_rw;
  logic [7:0] bus_wdata, bus_rdata;
  logic       busy, disp_on, cursor_on, blink_on, entry_inc, entry_shift;
  logic       bus_8bit, two_lines, tall_font;
  logic [6:0] disp_offset;

  chardisp_cmd u0 (.*);

  localparam int LONGC  = 410;
  localparam int SHORTC = 10;

  int n_chk = 0, n_fail = 0;
  int last_rd, n;

  // reference model state
  int m_dd[128], m_cg[64];
  int m_ac, m_cgsel, m_inc, m_sh, m_d, m_c, m_b, m_dl, m_n, m_f, m_off, m_busy;
  int b, acc, lng;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int mstep(input int a, input int up);
    if (m_cgsel != 0) return (a + (up != 0 ? 1 : 63)) % 64;
    return (a + (up != 0 ? 1 : 127)) % 128;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (m_dd[i]) m_dd[i] = 32'h20;
      foreach (m_cg[i]) m_cg[i] = 0;
      m_ac = 0; m_cgsel = 0; m_inc = 1; m_sh = 0; m_d = 0; m_c = 0; m_b = 0;
      m_dl = 1; m_n = 0; m_f = 0; m_off = 0; m_busy = 0;
    end else begin
      acc = 0; lng = 0;
      if (bus_en && m_busy == 0) begin
        if (!bus_rs && !bus_rw) begin
          b = bus_wdata;
          acc = (b != 0);
          if (b >= 128) begin m_ac = b % 128; m_cgsel = 0; end
          else if (b >= 64) begin m_ac = b % 64; m_cgsel = 1; end
          else if (b >= 32) begin m_dl = (b >> 4) & 1; m_n = (b >> 3) & 1; m_f = (b >> 2) & 1; end
          else if (b >= 16) begin
            if (b & 8) m_off = (b & 4) ? (m_off + 127) % 128 : (m_off + 1) % 128;
            else m_ac = mstep(m_ac, (b >> 2) & 1);
          end
          else if (b >= 8) begin m_d = (b >> 2) & 1; m_c = (b >> 1) & 1; m_b = b & 1; end
          else if (b >= 4) begin m_inc = (b >> 1) & 1; m_sh = b & 1; end
          else if (b >= 1) begin
            if (b == 1) foreach (m_dd[i]) m_dd[i] = 32'h20;
            m_ac = 0; m_cgsel = 0; m_off = 0; lng = 1;
          end
        end else if (bus_rs) begin
          acc = 1;
          if (!bus_rw) begin
            if (m_cgsel != 0) m_cg[m_ac % 64] = bus_wdata; else m_dd[m_ac] = bus_wdata;
          end
          m_ac = mstep(m_ac, m_inc);
          if (m_sh != 0) m_off = (m_off + (m_inc != 0 ? 1 : 127)) % 128;
        end
      end
      if (acc != 0) m_busy = (lng != 0) ? LONGC : SHORTC;
      else if (m_busy > 0) m_busy--;
    end
  end

  // compare against the model every cycle
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R11 busy", busy, m_busy != 0);
      chk("R5 modes", {disp_on, cursor_on, blink_on, entry_inc, entry_shift, bus_8bit, two_lines, tall_font},
          {m_d[0], m_c[0], m_b[0], m_inc[0], m_sh[0], m_dl[0], m_n[0], m_f[0]});
      chk("R6 offset", disp_offset, m_off);
      if (bus_rs) chk("R9 data port", bus_rdata, (m_cgsel != 0) ? m_cg[m_ac % 64] : m_dd[m_ac]);
      else        chk("R10 status port", bus_rdata, ((m_busy != 0) << 7) | m_ac);
    end
  end

  task automatic access(input logic rs, input logic rw, input logic [7:0] d);
    bus_en = 1'b1; bus_rs = rs; bus_rw = rw; bus_wdata = d;
    #1 last_rd = bus_rdata;
    @(negedge clk); #1;
    bus_en = 1'b0; bus_rs = 1'b0; bus_rw = 1'b0;
  endtask

  task automatic count_busy(output int c);
    c = 0;
    while (busy) begin c++; @(negedge clk); end
    #1;
  endtask

  task automatic cmd(input logic [7:0] d);
    access(1'b0, 1'b0, d); count_busy(n);
  endtask

  task automatic wr(input logic [7:0] d);
    access(1'b1, 1'b0, d); count_busy(n);
  endtask

  task automatic status(input string tag, input int exp);
    access(1'b0, 1'b1, 8'h00); chk(tag, last_rd, exp);
  endtask

  task automatic rd(input string tag, input int exp);
    access(1'b1, 1'b1, 8'h00); chk(tag, last_rd, exp); count_busy(n);
  endtask

  initial begin
    bus_en = 0; bus_rs = 0; bus_rw = 0; bus_wdata = 0; rst_n = 0;
    repeat (3) @(negedge clk);
    #1 rst_n = 1;
    @(negedge clk); #1;
    // R1 reset state
    chk("R1 busy", busy, 0);
    chk("R1 offset", disp_offset, 0);
    chk("R1 modes", {disp_on, cursor_on, blink_on, entry_inc, entry_shift, bus_8bit, two_lines, tall_font}, 8'b0001_0100);
    status("R1 status", 8'h00);
    rd("R1 blank ram", 8'h20);
    // R2 zero byte is no command
    access(1'b0, 1'b0, 8'h00);
    chk("R2 null byte busy", busy, 0);
    // R5 + R11 short busy
    access(1'b0, 1'b0, 8'h3C); count_busy(n);
    chk("R11 short busy length", n, SHORTC);
    chk("R5 function bits", {bus_8bit, two_lines, tall_font}, 3'b111);
    // R12 instruction ignored while busy
    access(1'b0, 1'b0, 8'h3C); access(1'b0, 1'b0, 8'h20); count_busy(n);
    chk("R12 ignored func", tall_font, 1);
    cmd(8'h0D);
    chk("R5 display bits", {disp_on, cursor_on, blink_on}, 3'b101);
    cmd(8'h06);
    // R7 display-data address load
    cmd(8'hFE);
    status("R7 dd load", 126);
    // R8 increment wrap
    wr(8'h41); wr(8'h42); wr(8'h43);
    status("R8 dd inc wrap", 1);
    // R2 0xFF decodes as display-data address 127
    cmd(8'hFF);
    rd("R9 read byte", 8'h42);
    status("R9 read steps", 0);
    // R8 decrement wrap
    cmd(8'h04); wr(8'h5A);
    status("R8 dd dec wrap", 127);
    // R8 auto shift
    cmd(8'h07); wr(8'h44);
    chk("R8 auto shift", disp_offset, 1);
    // R6 display and cursor shifts
    cmd(8'h1C); chk("R6 right", disp_offset, 0);
    cmd(8'h1C); chk("R6 right wrap", disp_offset, 127);
    cmd(8'h18); chk("R6 left", disp_offset, 0);
    status("R6 before cursor", 0);
    cmd(8'h14); status("R6 cursor right", 1);
    cmd(8'h10); status("R6 cursor left", 0);
    cmd(8'h06);
    // R2 0x7F decodes as character-generator address 63; R8 wrap in 64
    cmd(8'h7F); wr(8'h15);
    status("R8 cg inc wrap", 0);
    cmd(8'h04); wr(8'h0A);
    status("R8 cg dec wrap", 63);
    rd("R9 cg read", 8'h15);
    cmd(8'h41);
    status("R2 cg addr 1", 1);
    cmd(8'h06);
    // R4 home, R10 status while busy, R12 data write while busy
    access(1'b0, 1'b0, 8'h02);
    access(1'b0, 1'b1, 8'h00);
    chk("R10 busy bit", last_rd, 8'h80);
    access(1'b1, 1'b0, 8'h77);
    count_busy(n);
    chk("R11 long busy length", n + 2, LONGC);
    status("R4 home counter", 0);
    chk("R4 home offset", disp_offset, 0);
    cmd(8'hFE);
    rd("R4 ram kept", 8'h41);
    cmd(8'h80);
    rd("R12 write ignored", 8'h5A);
    // R3 clear
    cmd(8'h09);
    access(1'b0, 1'b0, 8'h01); count_busy(n);
    chk("R11 clear busy length", n, LONGC);
    status("R3 clear counter", 0);
    rd("R3 blank at 0", 8'h20);
    cmd(8'hFE);
    rd("R3 blank at 126", 8'h20);
    chk("R3 offset", disp_offset, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #1_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule